// File: doc/BRIEF.md
# Exception Entry Vector Logic

This block performs the state update that a processor core makes at the moment it enters an exception handler. The core presents the kind of exception, the program counter of the faulting instruction, a flag that marks a branch delay slot, and its current status, cause, vector-base and debug state. The block works out the handler address and the new values of the saved-PC registers, the cause register, the status bits and the debug state. On the cycle after a one-cycle `take_i` strobe, all of these appear on registered outputs.

There are three entry paths. The general path covers interrupts, TLB faults, address errors, traps and cache errors. The error path covers the non-maskable interrupt and the soft reset. The debug path covers the six debug causes. The general path picks its vector from a boot-time base or a programmable base, and the offset depends on the kind of exception, the interrupt-vector bit, the TLB refill condition and the exception-level bit. The saved PC and the delay-slot cause bit are written only when the exception level is not already set. A kind code that is not defined raises `bad_o`, and every state output then copies its input unchanged.

Kind codes on `kind_i`: the general kinds use their own cause code as the kind code (0, 1 to 13, 15, 18, 22 to 25, 30). The error kinds are 16 (NMI) and 17 (soft reset). The debug kinds are 19 (single step), 20 (debug interrupt), 21 (instruction breakpoint), 26 (breakpoint instruction), 27 (data break on store) and 28 (data break on load). Kinds 14, 29 and 31 are undefined. The cause register has the code field at bits [6:2], the coprocessor field at [29:28], the interrupt-vector bit at 23 and the delay-slot bit at 31. The debug flag bits are, from bit 0 upward: single step, debug interrupt, instruction breakpoint, breakpoint instruction, data break store, data break load.

Top module: `exc_entry`

## Requirements
- R1: While reset is held, and after it is released until the first `take_i`, `done_o`, `bad_o` and every state output are zero.
- R2: A `take_i` pulse drives `done_o` high for exactly the next cycle, and all outputs update on that same clock edge. Without `take_i`, `done_o` is low and the outputs hold their values.
- R3: For a general kind, the handler address is the base plus an offset. The base is 0xBFC00200 when `bev_i` is set; otherwise it is `ebase_i` with bits [9:0] cleared. The offset is 0x180 unless R4, R5 or R6 applies.
- R4: An interrupt (kind 0) uses offset 0x200 when `cause_i` bit 23 is set.
- R5: A TLB load (kind 2) or TLB store (kind 3) uses offset 0x000 when `refill_i` is set and `exl_i` is clear; otherwise it uses 0x180.
- R6: A cache error (kind 30) uses offset 0x100 when `bev_i` is set and 0x20000100 when it is clear.
- R7: For a general kind with `exl_i` clear, the block sets `epc_o` to `pc_i`-4 and cause bit 31 to 1 in a delay slot, or to `pc_i` and bit 31 to 0 otherwise. It also sets `exl_o` and drives `mode_o` to 0 (kernel). With `exl_i` set, `epc_o`, cause bit 31 and `mode_o` keep their input values.
- R8: A general kind writes its kind code into cause bits [6:2]. The other cause bits keep their input values unless R7 or R9 changes them.
- R9: Coprocessor unusable (kind 11) also writes `cop_num_i` into cause bits [29:28].
- R10: NMI (16) and soft reset (17) jump to 0xBFC00000 and store `errpc_o` with the delay-slot rule of R7. They set `erl_o` and `bev_o`, set `nmi_flag_o` or `srst_flag_o` respectively, and drive `mode_o` to 0. Cause bit 31 is cleared when `exl_i` is clear.
- R11: A debug kind sets its own debug flag bit and keeps the other flag bits. It stores `dbgpc_o` with the delay-slot rule (single step always stores `pc_i`), sets `dbg_mode_o`, drives `mode_o` to 0 and jumps to 0xBFC00480. Cause bit 31 is cleared when `exl_i` is clear.
- R12: An interrupt (kind 0) that arrives while `dbg_mode_i` is set is handled as a debug interrupt (flag bit 1) and not as a general exception.
- R13: An undefined kind (14, 29, 31) drives `bad_o` high for one cycle. `pc_o` and every state output then equal their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | One-cycle strobe: enter an exception now |
| kind_i | input | 5 | Exception kind code |
| pc_i | input | XLEN | PC of the faulting instruction |
| in_slot_i | input | 1 | Instruction sits in a branch delay slot |
| cop_num_i | input | 2 | Coprocessor number for coprocessor unusable |
| refill_i | input | 1 | TLB fault was a miss (refill condition) |
| exl_i | input | 1 | Exception level currently set |
| erl_i | input | 1 | Error level currently set |
| bev_i | input | 1 | Bootstrap vectors selected |
| nmi_flag_i | input | 1 | Current NMI status bit |
| srst_flag_i | input | 1 | Current soft-reset status bit |
| mode_i | input | 2 | Current privilege mode (0 = kernel) |
| cause_i | input | XLEN | Current cause register |
| ebase_i | input | XLEN | Programmable vector base |
| epc_i | input | XLEN | Current exception PC |
| errpc_i | input | XLEN | Current error PC |
| dbgpc_i | input | XLEN | Current debug PC |
| dbg_mode_i | input | 1 | Debug mode currently active |
| dbg_flags_i | input | 6 | Current debug cause flags |
| done_o | output | 1 | Results valid (one cycle after take_i) |
| bad_o | output | 1 | Kind code was undefined |
| pc_o | output | XLEN | Handler address |
| epc_o | output | XLEN | New exception PC |
| errpc_o | output | XLEN | New error PC |
| dbgpc_o | output | XLEN | New debug PC |
| cause_o | output | XLEN | New cause register |
| exl_o | output | 1 | New exception level |
| erl_o | output | 1 | New error level |
| bev_o | output | 1 | New bootstrap-vector bit |
| nmi_flag_o | output | 1 | New NMI status bit |
| srst_flag_o | output | 1 | New soft-reset status bit |
| mode_o | output | 2 | New privilege mode |
| dbg_mode_o | output | 1 | New debug-mode state |
| dbg_flags_o | output | 6 | New debug cause flags |

## Verification
Two functions can meet in one cycle: an external interrupt strobe and an active debug mode. The first would pick a general vector, and the second turns the same strobe into a debug interrupt. The bench presents kind 0 with `dbg_mode_i` high and the interrupt-vector bit set. It judges the result by the debug vector, the debug-interrupt flag, and `epc_o`, `exl_o` and the cause code field staying untouched. A second overlap is an exception taken in a delay slot while the exception level is already set. The bench provokes it back to back with a normal entry and expects the cause code to change while the saved PC and the slot bit hold.

// File: rtl/exc_pkg.sv
package exc_pkg;

  // Field positions in the cause word
  localparam int CODE_LSB  = 2;
  localparam int CODE_W    = 5;
  localparam int CE_LSB    = 28;
  localparam int CE_W      = 2;
  localparam int IV_BIT    = 23;
  localparam int DBG_FLAGS = 6;
  localparam int KIND_W    = 5;

  // Kind codes (general kinds equal their cause code)
  localparam logic [KIND_W-1:0] K_INT   = 5'd0;
  localparam logic [KIND_W-1:0] K_TLBLD = 5'd2;
  localparam logic [KIND_W-1:0] K_TLBST = 5'd3;
  localparam logic [KIND_W-1:0] K_COPU  = 5'd11;
  localparam logic [KIND_W-1:0] K_NMI   = 5'd16;
  localparam logic [KIND_W-1:0] K_SRST  = 5'd17;
  localparam logic [KIND_W-1:0] K_STEP  = 5'd19;
  localparam logic [KIND_W-1:0] K_DINT  = 5'd20;
  localparam logic [KIND_W-1:0] K_DIB   = 5'd21;
  localparam logic [KIND_W-1:0] K_DBP   = 5'd26;
  localparam logic [KIND_W-1:0] K_DDBS  = 5'd27;
  localparam logic [KIND_W-1:0] K_DDBL  = 5'd28;
  localparam logic [KIND_W-1:0] K_CACHE = 5'd30;

  typedef enum logic [1:0] {
    CL_GEN = 2'd0,
    CL_ERR = 2'd1,
    CL_DBG = 2'd2,
    CL_BAD = 2'd3
  } exc_class_e;

endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_pkg::*;
(
  input  logic [KIND_W-1:0]    kind_i,
  input  logic                 dbg_mode_i,
  output exc_class_e           cls_o,
  output logic [CODE_W-1:0]    code_o,
  output logic [DBG_FLAGS-1:0] dbg_hit_o,
  output logic                 step_o,
  output logic                 nmi_o,
  output logic                 int_o,
  output logic                 tlb_o,
  output logic                 cache_o,
  output logic                 copu_o
);

  always_comb begin
    cls_o     = CL_BAD;
    code_o    = kind_i;
    dbg_hit_o = '0;
    case (kind_i) inside
      K_INT: begin
        if (dbg_mode_i) begin
          cls_o        = CL_DBG;
          dbg_hit_o[1] = 1'b1;
        end else begin
          cls_o = CL_GEN;
        end
      end
      [5'd1:5'd13], 5'd15, 5'd18, [5'd22:5'd25], K_CACHE: cls_o = CL_GEN;
      K_NMI, K_SRST: cls_o = CL_ERR;
      K_STEP: begin cls_o = CL_DBG; dbg_hit_o[0] = 1'b1; end
      K_DINT: begin cls_o = CL_DBG; dbg_hit_o[1] = 1'b1; end
      K_DIB:  begin cls_o = CL_DBG; dbg_hit_o[2] = 1'b1; end
      K_DBP:  begin cls_o = CL_DBG; dbg_hit_o[3] = 1'b1; end
      K_DDBS: begin cls_o = CL_DBG; dbg_hit_o[4] = 1'b1; end
      K_DDBL: begin cls_o = CL_DBG; dbg_hit_o[5] = 1'b1; end
      default: cls_o = CL_BAD;
    endcase
  end

  assign step_o  = (kind_i == K_STEP);
  assign nmi_o   = (kind_i == K_NMI);
  assign int_o   = (kind_i == K_INT) && !dbg_mode_i;
  assign tlb_o   = (kind_i == K_TLBLD) || (kind_i == K_TLBST);
  assign cache_o = (kind_i == K_CACHE);
  assign copu_o  = (kind_i == K_COPU);

endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int          XLEN           = 32,
  parameter logic [31:0] BOOT_GEN_BASE  = 32'hBFC0_0200,
  parameter logic [31:0] OFF_GEN        = 32'h0000_0180,
  parameter logic [31:0] OFF_INT        = 32'h0000_0200,
  parameter logic [31:0] OFF_REFILL     = 32'h0000_0000,
  parameter logic [31:0] OFF_CACHE_BOOT = 32'h0000_0100,
  parameter logic [31:0] OFF_CACHE_RUN  = 32'h2000_0100,
  parameter int          BASE_LOW       = 10
) (
  input  logic            int_i,
  input  logic            iv_i,
  input  logic            tlb_i,
  input  logic            refill_i,
  input  logic            exl_i,
  input  logic            cache_i,
  input  logic            bev_i,
  input  logic [XLEN-1:0] ebase_i,
  output logic [XLEN-1:0] vec_o
);

  localparam logic [XLEN-1:0] LOW_MASK = XLEN'((64'd1 << BASE_LOW) - 64'd1);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base = bev_i ? XLEN'(BOOT_GEN_BASE) : (ebase_i & ~LOW_MASK);

  always_comb begin
    offset = XLEN'(OFF_GEN);
    if (int_i && iv_i)
      offset = XLEN'(OFF_INT);
    else if (tlb_i && refill_i && !exl_i)
      offset = XLEN'(OFF_REFILL);
    else if (cache_i)
      offset = bev_i ? XLEN'(OFF_CACHE_BOOT) : XLEN'(OFF_CACHE_RUN);
  end

  // The run-time cache offset carries past bit 9, so a real add is needed
  assign vec_o = base + offset;

endmodule

// File: rtl/exc_save_pc.sv
module exc_save_pc #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            slot_i,
  output logic [XLEN-1:0] saved_o
);

  // A faulting delay-slot instruction resumes at its branch
  assign saved_o = slot_i ? (pc_i - XLEN'(INSN_BYTES)) : pc_i;

endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          INSN_BYTES = 4,
  parameter int          BASE_LOW   = 10,
  parameter logic [31:0] ERR_VEC    = 32'hBFC0_0000,
  parameter logic [31:0] DBG_VEC    = 32'hBFC0_0480,
  parameter logic [31:0] GEN_BOOT   = 32'hBFC0_0200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take_i,
  input  logic [KIND_W-1:0]    kind_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic                 in_slot_i,
  input  logic [CE_W-1:0]      cop_num_i,
  input  logic                 refill_i,
  input  logic                 exl_i,
  input  logic                 erl_i,
  input  logic                 bev_i,
  input  logic                 nmi_flag_i,
  input  logic                 srst_flag_i,
  input  logic [1:0]           mode_i,
  input  logic [XLEN-1:0]      cause_i,
  input  logic [XLEN-1:0]      ebase_i,
  input  logic [XLEN-1:0]      epc_i,
  input  logic [XLEN-1:0]      errpc_i,
  input  logic [XLEN-1:0]      dbgpc_i,
  input  logic                 dbg_mode_i,
  input  logic [DBG_FLAGS-1:0] dbg_flags_i,
  output logic                 done_o,
  output logic                 bad_o,
  output logic [XLEN-1:0]      pc_o,
  output logic [XLEN-1:0]      epc_o,
  output logic [XLEN-1:0]      errpc_o,
  output logic [XLEN-1:0]      dbgpc_o,
  output logic [XLEN-1:0]      cause_o,
  output logic                 exl_o,
  output logic                 erl_o,
  output logic                 bev_o,
  output logic                 nmi_flag_o,
  output logic                 srst_flag_o,
  output logic [1:0]           mode_o,
  output logic                 dbg_mode_o,
  output logic [DBG_FLAGS-1:0] dbg_flags_o
);

  localparam int          BD_BIT = XLEN - 1;
  localparam logic [1:0]  KERNEL = 2'd0;

  // ---------------- classification ----------------
  exc_class_e           cls;
  logic [CODE_W-1:0]    code;
  logic [DBG_FLAGS-1:0] dbg_hit;
  logic                 is_step, is_nmi, is_int, is_tlb, is_cache, is_copu;

  exc_decode u_dec (
    .kind_i     (kind_i),
    .dbg_mode_i (dbg_mode_i),
    .cls_o      (cls),
    .code_o     (code),
    .dbg_hit_o  (dbg_hit),
    .step_o     (is_step),
    .nmi_o      (is_nmi),
    .int_o      (is_int),
    .tlb_o      (is_tlb),
    .cache_o    (is_cache),
    .copu_o     (is_copu)
  );

  // ---------------- general vector ----------------
  logic [XLEN-1:0] gen_vec;

  exc_vector #(
    .XLEN          (XLEN),
    .BOOT_GEN_BASE (GEN_BOOT),
    .BASE_LOW      (BASE_LOW)
  ) u_vec (
    .int_i    (is_int),
    .iv_i     (cause_i[IV_BIT]),
    .tlb_i    (is_tlb),
    .refill_i (refill_i),
    .exl_i    (exl_i),
    .cache_i  (is_cache),
    .bev_i    (bev_i),
    .ebase_i  (ebase_i),
    .vec_o    (gen_vec)
  );

  // ---------------- resume address ----------------
  logic [XLEN-1:0] resume_pc;

  exc_save_pc #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES)
  ) u_save (
    .pc_i    (pc_i),
    .slot_i  (in_slot_i),
    .saved_o (resume_pc)
  );

  // ---------------- debug flag merge ----------------
  logic [DBG_FLAGS-1:0] dbg_flags_set;

  for (genvar g = 0; g < DBG_FLAGS; g++) begin : g_dflag
    assign dbg_flags_set[g] = dbg_flags_i[g] | dbg_hit[g];
  end

  // ---------------- next state ----------------
  logic                 bad_n;
  logic [XLEN-1:0]      pc_n, epc_n, errpc_n, dbgpc_n, cause_n;
  logic                 exl_n, erl_n, bev_n, nmi_n, srst_n, dbgm_n;
  logic [1:0]           mode_n;
  logic [DBG_FLAGS-1:0] dflags_n;

  always_comb begin
    bad_n    = 1'b0;
    pc_n     = pc_i;
    epc_n    = epc_i;
    errpc_n  = errpc_i;
    dbgpc_n  = dbgpc_i;
    cause_n  = cause_i;
    exl_n    = exl_i;
    erl_n    = erl_i;
    bev_n    = bev_i;
    nmi_n    = nmi_flag_i;
    srst_n   = srst_flag_i;
    mode_n   = mode_i;
    dbgm_n   = dbg_mode_i;
    dflags_n = dbg_flags_i;

    unique case (cls)
      CL_GEN: begin
        pc_n = gen_vec;
        cause_n[CODE_LSB +: CODE_W] = code;
        if (is_copu)
          cause_n[CE_LSB +: CE_W] = cop_num_i;
        if (!exl_i) begin
          epc_n          = resume_pc;
          cause_n[BD_BIT] = in_slot_i;
          exl_n          = 1'b1;
          mode_n         = KERNEL;
        end
      end
      CL_ERR: begin
        pc_n    = XLEN'(ERR_VEC);
        errpc_n = resume_pc;
        erl_n   = 1'b1;
        bev_n   = 1'b1;
        mode_n  = KERNEL;
        if (is_nmi) nmi_n  = 1'b1;
        else        srst_n = 1'b1;
        if (!exl_i) cause_n[BD_BIT] = 1'b0;
      end
      CL_DBG: begin
        pc_n     = XLEN'(DBG_VEC);
        dbgpc_n  = is_step ? pc_i : resume_pc;
        dbgm_n   = 1'b1;
        dflags_n = dbg_flags_set;
        mode_n   = KERNEL;
        if (!exl_i) cause_n[BD_BIT] = 1'b0;
      end
      default: bad_n = 1'b1;
    endcase
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      bad_o       <= 1'b0;
      pc_o        <= '0;
      epc_o       <= '0;
      errpc_o     <= '0;
      dbgpc_o     <= '0;
      cause_o     <= '0;
      exl_o       <= 1'b0;
      erl_o       <= 1'b0;
      bev_o       <= 1'b0;
      nmi_flag_o  <= 1'b0;
      srst_flag_o <= 1'b0;
      mode_o      <= '0;
      dbg_mode_o  <= 1'b0;
      dbg_flags_o <= '0;
    end else begin
      done_o <= take_i;
      bad_o  <= take_i && bad_n;
      if (take_i) begin
        pc_o        <= pc_n;
        epc_o       <= epc_n;
        errpc_o     <= errpc_n;
        dbgpc_o     <= dbgpc_n;
        cause_o     <= cause_n;
        exl_o       <= exl_n;
        erl_o       <= erl_n;
        bev_o       <= bev_n;
        nmi_flag_o  <= nmi_n;
        srst_flag_o <= srst_n;
        mode_o      <= mode_n;
        dbg_mode_o  <= dbgm_n;
        dbg_flags_o <= dflags_n;
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] ERR_VEC    = 32'hBFC0_0000,
  parameter logic [31:0] DBG_VEC    = 32'hBFC0_0480
) (
  input logic              clk,
  input logic              rst,
  input logic              take_i,
  input logic [KIND_W-1:0] kind_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              in_slot_i,
  input logic              exl_i,
  input logic              erl_i,
  input logic [1:0]        mode_i,
  input logic [XLEN-1:0]   epc_i,
  input logic              done_o,
  input logic              bad_o,
  input logic [XLEN-1:0]   pc_o,
  input logic [XLEN-1:0]   epc_o,
  input logic [XLEN-1:0]   cause_o,
  input logic              exl_o,
  input logic              erl_o,
  input logic              bev_o,
  input logic [1:0]        mode_o,
  input logic              dbg_mode_o
);

  logic gen_kind, err_kind, dbg_kind, undef_kind;
  assign gen_kind   = (kind_i >= 5'd1) && (kind_i <= 5'd13);
  assign err_kind   = (kind_i == K_NMI) || (kind_i == K_SRST);
  assign dbg_kind   = (kind_i == K_STEP) || (kind_i == K_DIB) || (kind_i == K_DDBL);
  assign undef_kind = (kind_i == 5'd14) || (kind_i == 5'd29) || (kind_i == 5'd31);

  // R2
  done_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
    take_i |=> done_o);

  // R2
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> !done_o);

  // R7
  gen_entry_epc_chk: assert property (@(posedge clk) disable iff (rst)
    take_i && gen_kind && !exl_i |=>
      exl_o && (mode_o == 2'd0) &&
      (epc_o == ($past(in_slot_i) ? $past(pc_i) - XLEN'(INSN_BYTES) : $past(pc_i))));

  // R7
  nested_keeps_epc_chk: assert property (@(posedge clk) disable iff (rst)
    take_i && gen_kind && exl_i |=>
      exl_o && (epc_o == $past(epc_i)) && (mode_o == $past(mode_i)));

  // R8
  code_field_chk: assert property (@(posedge clk) disable iff (rst)
    take_i && gen_kind |=> cause_o[CODE_LSB +: CODE_W] == $past(kind_i));

  // R10
  err_vector_chk: assert property (@(posedge clk) disable iff (rst)
    take_i && err_kind |=> (pc_o == XLEN'(ERR_VEC)) && erl_o && bev_o && (mode_o == 2'd0));

  // R11
  dbg_vector_chk: assert property (@(posedge clk) disable iff (rst)
    take_i && dbg_kind |=> (pc_o == XLEN'(DBG_VEC)) && dbg_mode_o);

  // R13
  undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
    take_i && undef_kind |=>
      bad_o && (pc_o == $past(pc_i)) && (exl_o == $past(exl_i)) && (erl_o == $past(erl_i)));

endmodule

bind exc_entry exc_entry_chk #(
  .XLEN       (XLEN),
  .INSN_BYTES (INSN_BYTES),
  .ERR_VEC    (ERR_VEC),
  .DBG_VEC    (DBG_VEC)
) u_chk (.*);

// File: tb/exc_entry_test.sv
module exc_entry_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take = 1'b0;
  logic [4:0]  kind = '0;
  logic [31:0] pc = '0;
  logic        slot = 1'b0;
  logic [1:0]  cop = '0;
  logic        refill = 1'b0;
  logic        exl = 1'b0, erl = 1'b0, bev = 1'b0, nmif = 1'b0, srstf = 1'b0;
  logic [1:0]  mode = '0;
  logic [31:0] cause = '0, ebase = '0, epc = '0, errpc = '0, dbgpc = '0;
  logic        dbgm = 1'b0;
  logic [5:0]  dflags = '0;

  logic        done_o, bad_o;
  logic [31:0] pc_o, epc_o, errpc_o, dbgpc_o, cause_o;
  logic        exl_o, erl_o, bev_o, nmi_flag_o, srst_flag_o, dbg_mode_o;
  logic [1:0]  mode_o;
  logic [5:0]  dbg_flags_o;

  always #5 clk = ~clk;

  exc_entry uut (
    .clk(clk), .rst(rst), .take_i(take), .kind_i(kind), .pc_i(pc),
    .in_slot_i(slot), .cop_num_i(cop), .refill_i(refill), .exl_i(exl),
    .erl_i(erl), .bev_i(bev), .nmi_flag_i(nmif), .srst_flag_i(srstf),
    .mode_i(mode), .cause_i(cause), .ebase_i(ebase), .epc_i(epc),
    .errpc_i(errpc), .dbgpc_i(dbgpc), .dbg_mode_i(dbgm), .dbg_flags_i(dflags),
    .done_o(done_o), .bad_o(bad_o), .pc_o(pc_o), .epc_o(epc_o),
    .errpc_o(errpc_o), .dbgpc_o(dbgpc_o), .cause_o(cause_o), .exl_o(exl_o),
    .erl_o(erl_o), .bev_o(bev_o), .nmi_flag_o(nmi_flag_o),
    .srst_flag_o(srst_flag_o), .mode_o(mode_o), .dbg_mode_o(dbg_mode_o),
    .dbg_flags_o(dbg_flags_o)
  );

  typedef struct {
    string       tag;
    logic        bad;
    logic [31:0] pc, epc, errpc, dbgpc, cause;
    logic        exl, erl, bev, nmi, srst, dbgm;
    logic [1:0]  mode;
    logic [5:0]  dflags;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic [31:0] last_pc = '0;

  task automatic check(string tag, string field, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, field, act, expv);
    end
  endtask

  // Reference model written from the requirement list
  function automatic exp_t model(string tag);
    exp_t e;
    logic [4:0]  k;
    logic [31:0] resume, base, off;
    int          di;
    e.tag = tag; e.bad = 1'b0; e.pc = pc; e.epc = epc; e.errpc = errpc;
    e.dbgpc = dbgpc; e.cause = cause; e.exl = exl; e.erl = erl; e.bev = bev;
    e.nmi = nmif; e.srst = srstf; e.dbgm = dbgm; e.mode = mode; e.dflags = dflags;
    k = kind;
    if (k == 5'd0 && dbgm) k = 5'd20;                // R12
    resume = slot ? pc - 32'd4 : pc;
    di = -1;
    case (k)
      5'd19: di = 0; 5'd20: di = 1; 5'd21: di = 2;
      5'd26: di = 3; 5'd27: di = 4; 5'd28: di = 5;
      default: di = -1;
    endcase
    if (k <= 5'd13 || k == 5'd15 || k == 5'd18 || (k >= 5'd22 && k <= 5'd25) || k == 5'd30) begin
      base = bev ? 32'hBFC0_0200 : {ebase[31:10], 10'd0};
      off  = 32'h180;
      if (k == 5'd0 && cause[23]) off = 32'h200;
      if ((k == 5'd2 || k == 5'd3) && refill && !exl) off = 32'h0;
      if (k == 5'd30) off = bev ? 32'h100 : 32'h2000_0100;
      e.pc = base + off;
      e.cause[6:2] = k;
      if (k == 5'd11) e.cause[29:28] = cop;
      if (!exl) begin
        e.epc = resume; e.cause[31] = slot; e.exl = 1'b1; e.mode = 2'd0;
      end
    end else if (k == 5'd16 || k == 5'd17) begin
      e.pc = 32'hBFC0_0000; e.errpc = resume; e.erl = 1'b1; e.bev = 1'b1;
      e.mode = 2'd0;
      if (k == 5'd16) e.nmi = 1'b1; else e.srst = 1'b1;
      if (!exl) e.cause[31] = 1'b0;
    end else if (di >= 0) begin
      e.pc = 32'hBFC0_0480; e.dbgm = 1'b1; e.mode = 2'd0;
      e.dbgpc = (k == 5'd19) ? pc : resume;
      e.dflags[di] = 1'b1;
      if (!exl) e.cause[31] = 1'b0;
    end else begin
      e.bad = 1'b1;
    end
    return e;
  endfunction

  // Driver: called at a falling edge; holds the strobe for one cycle
  task automatic fire(string tag);
    exp_q.push_back(model(tag));
    take = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    take = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic defaults();
    slot = 0; cop = 0; refill = 0; exl = 0; erl = 0; bev = 0; nmif = 0; srstf = 0;
    mode = 2'd2; cause = 32'h0000_0300; ebase = 32'h8000_1234;
    epc = 32'h1111_1110; errpc = 32'h2222_2220; dbgpc = 32'h3333_3330;
    dbgm = 0; dflags = 6'b000000; pc = 32'h0040_1000;
  endtask

  // Monitor: compares each result against the head of the queue
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 done_o without a pending item: actual 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "bad",    32'(bad_o),       32'(e.bad));
        check(e.tag, "pc",     pc_o,             e.pc);
        check(e.tag, "epc",    epc_o,            e.epc);
        check(e.tag, "errpc",  errpc_o,          e.errpc);
        check(e.tag, "dbgpc",  dbgpc_o,          e.dbgpc);
        check(e.tag, "cause",  cause_o,          e.cause);
        check(e.tag, "exl",    32'(exl_o),       32'(e.exl));
        check(e.tag, "erl",    32'(erl_o),       32'(e.erl));
        check(e.tag, "bev",    32'(bev_o),       32'(e.bev));
        check(e.tag, "nmi",    32'(nmi_flag_o),  32'(e.nmi));
        check(e.tag, "srst",   32'(srst_flag_o), 32'(e.srst));
        check(e.tag, "mode",   32'(mode_o),      32'(e.mode));
        check(e.tag, "dbgm",   32'(dbg_mode_o),  32'(e.dbgm));
        check(e.tag, "dflags", 32'(dbg_flags_o), 32'(e.dflags));
        last_pc = e.pc;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    defaults();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done", 32'(done_o), 32'd0);
    check("R1", "pc",   pc_o,        32'd0);
    check("R1", "cause", cause_o,    32'd0);
    check("R1", "flags", {25'd0, exl_o, erl_o, bev_o, dbg_mode_o, dbg_flags_o[2:0]}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "bad", 32'(bad_o), 32'd0);

    // R3 R7 R8: syscall, not in a slot, run-time base
    kind = 5'd8; fire("R3 R7 R8 syscall");
    // R7: overflow in a slot, then nested break with exl set (back to back)
    kind = 5'd12; slot = 1; fire("R7 R8 overflow slot");
    kind = 5'd9; exl = 1; cause = 32'h0000_0300; fire("R7 R8 nested break");
    idle(1);
    // R2: outputs hold with no strobe
    check("R2", "done idle", 32'(done_o), 32'd0);
    check("R2", "pc hold",   pc_o,        last_pc);
    defaults();

    // R4 interrupt offset
    kind = 5'd0; cause = 32'h0080_0000; fire("R4 int iv");
    kind = 5'd0; cause = 32'h0000_0000; fire("R4 int no iv");
    // R5 TLB offsets
    kind = 5'd2; refill = 1; fire("R5 tlb load refill");
    kind = 5'd3; refill = 1; exl = 1; fire("R5 tlb store refill exl");
    kind = 5'd3; refill = 0; exl = 0; fire("R5 tlb store invalid");
    // R3 bootstrap base
    kind = 5'd4; bev = 1; fire("R3 addr err boot");
    // R6 cache error
    kind = 5'd30; bev = 1; fire("R6 cache boot");
    kind = 5'd30; bev = 0; fire("R6 cache run");
    // R9 coprocessor number
    kind = 5'd11; cop = 2'd2; cause = 32'h8000_0000; fire("R9 copu");
    idle(1);
    defaults();

    // R10 error path
    kind = 5'd16; slot = 1; cause = 32'h8000_0000; fire("R10 nmi slot");
    kind = 5'd17; slot = 0; exl = 1; fire("R10 soft reset");
    exl = 0;
    // R11 debug path
    kind = 5'd19; slot = 1; cause = 32'h8000_0000; fire("R11 step slot");
    kind = 5'd21; slot = 1; dflags = 6'b100000; fire("R11 dib slot");
    kind = 5'd28; slot = 0; fire("R11 ddbl");
    // R12 interrupt during debug mode, with the vector bit also set
    kind = 5'd0; dbgm = 1; cause = 32'h0080_0000; dflags = 6'b000001; fire("R12 int in debug");
    dbgm = 0;
    // R13 undefined kinds
    kind = 5'd14; fire("R13 kind14");
    kind = 5'd29; exl = 1; fire("R13 kind29");
    kind = 5'd31; erl = 1; fire("R13 kind31");
    idle(3);

    check("R2", "queue drained", 32'(exp_q.size()), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule